// File: doc/BRIEF.md
# Reuse-Gated Filter Cache Front-End

This block decides where a cache line lives on its way into a cache hierarchy. It pairs a small fully associative filter store with a larger direct-mapped main tag store. A line address that misses in both stores is installed only in the filter. A line reaches the main store only when it is looked up a second time while it is still held in the filter. Lines that are touched once are eventually pushed out of the filter by least-recently-used replacement and are never seen by the main store.

Each cycle with a valid lookup, both stores are probed in parallel. The block reports exactly one outcome: a filter hit, a main hit or a miss. It also issues a promote command or a fill command carrying the line address, so that a payload array and a memory interface outside this block can follow. Only tags are held here. A promotion that lands on an occupied main-store set overwrites that set, and the displaced line is dropped.

Top module: `reuseFilterTop`

## Requirements
- R1: After reset no line is resident: all outputs are low while no lookup is presented, and the first lookup of any address reports a miss.
- R2: A lookup that matches neither store raises missOut and fillValid with fillAddr equal to the lookup address. promoteValid stays low, and the line is written into the filter only.
- R3: A lookup that matches a filter entry raises hitFilter and promoteValid with promoteAddr equal to the lookup address, and fillValid stays low. In the same cycle the filter entry is freed and the line is written into the main store.
- R4: After a promotion, further lookups of that line report hitMain with neither promote nor fill, because the line is no longer in the filter.
- R5: The filter holds 8 lines. When all 8 are valid, a fill evicts the entry filled least recently, and that evicted line next reports a miss. The other entries still report hitFilter.
- R6: A fill uses a free filter slot before it evicts anything. A slot freed by a promotion is therefore refilled without any eviction, and the recency order of the remaining entries is kept.
- R7: The main store is direct-mapped on line-address bits [5:0] (64 sets). A promotion into an occupied set replaces the old line, which then reports a miss and is not returned to the filter.
- R8: With a lookup presented, exactly one of hitFilter, hitMain and missOut is high, and a line never matches both stores at once. With no lookup presented, all of them are low.
- R9: Cycles without a lookup change no state: a line held in the filter before idle cycles still reports hitFilter after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupAddr | input | 16 | Line address to look up |
| hitFilter | output | 1 | Line found in the filter store |
| hitMain | output | 1 | Line found in the main store |
| missOut | output | 1 | Line found in neither store |
| promoteValid | output | 1 | Command to move the line from the filter into the main store |
| promoteAddr | output | 16 | Address of the promoted line, zero when promoteValid is low |
| fillValid | output | 1 | Command to fetch the line into the filter |
| fillAddr | output | 16 | Address of the filled line, zero when fillValid is low |

## Verification
The bench first accesses a single line repeatedly, which separates the miss, the filter hit with promotion, and the main hit that follows. Two lines that share a main set are then promoted one after the other, which shows that the displaced line is dropped and does not fall back into the filter. A run of nine single-use lines shows the oldest filter entry being evicted while the others survive. After a promotion frees one slot, two more fills show that the freed slot is taken first and that the next fill evicts the true oldest line. Idle gaps between lookups show that state is held and that every output stays low.

// File: rtl/rfcPkg.sv
package rfcPkg;
  typedef struct packed {
    logic promote;
    logic fill;
  } rfcStrobe_t;
endpackage

// File: rtl/rfcData.sv
module rfcData import rfcPkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int FILT_N    = 8,
  parameter int MAIN_SETS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  rfcStrobe_t        strb,
  output logic              filterHit,
  output logic              mainHit
);
  localparam int IDX_W  = $clog2(MAIN_SETS);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int SLOT_W = $clog2(FILT_N);
  localparam int AGE_W  = SLOT_W;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(FILT_N - 1);

  logic [FILT_N-1:0]    fValid;
  logic [ADDR_W-1:0]    fTag [FILT_N];
  logic [AGE_W-1:0]     fAge [FILT_N];
  logic [MAIN_SETS-1:0] mValid;
  logic [TAG_W-1:0]     mTag [MAIN_SETS];

  logic [IDX_W-1:0]  setIdx;
  logic [TAG_W-1:0]  setTag;
  logic [FILT_N-1:0] matchVec;
  logic [SLOT_W-1:0] hitIdx, freeIdx, oldIdx, victimIdx;
  logic              anyFree;

  assign setIdx = lookupAddr[IDX_W-1:0];
  assign setTag = lookupAddr[ADDR_W-1:IDX_W];

  for (genvar g = 0; g < FILT_N; g++) begin : gMatch
    assign matchVec[g] = fValid[g] && (fTag[g] == lookupAddr);
  end

  assign filterHit = |matchVec;
  assign mainHit   = mValid[setIdx] && (mTag[setIdx] == setTag);

  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    oldIdx  = '0;
    anyFree = 1'b0;
    for (int i = FILT_N - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = SLOT_W'(i);
      if (!fValid[i]) begin
        freeIdx = SLOT_W'(i);
        anyFree = 1'b1;
      end
      if (fValid[i] && fAge[i] == OLDEST) oldIdx = SLOT_W'(i);
    end
    victimIdx = anyFree ? freeIdx : oldIdx;
  end

  // filter state: valid bits and recency ages
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fValid <= '0;
      for (int i = 0; i < FILT_N; i++) fAge[i] <= '0;
    end else if (strb.promote) begin
      fValid[hitIdx] <= 1'b0;
      for (int i = 0; i < FILT_N; i++)
        if (fValid[i] && fAge[i] > fAge[hitIdx]) fAge[i] <= fAge[i] - 1'b1;
    end else if (strb.fill) begin
      for (int i = 0; i < FILT_N; i++) begin
        if (SLOT_W'(i) == victimIdx) begin
          fValid[i] <= 1'b1;
          fAge[i]   <= '0;
        end else if (fValid[i]) begin
          fAge[i] <= fAge[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fill) fTag[victimIdx] <= lookupAddr;
    if (strb.promote) mTag[setIdx] <= setTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) mValid <= '0;
    else if (strb.promote) mValid[setIdx] <= 1'b1;
  end

  // R8
  no_dual_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> !(filterHit && mainHit));

  // R3
  promote_frees_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.promote |=> !fValid[$past(hitIdx)] && mValid[$past(setIdx)]
                     && mTag[$past(setIdx)] == $past(setTag));

  // R2
  fill_installs_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill |=> fValid[$past(victimIdx)] && fTag[$past(victimIdx)] == $past(lookupAddr));

  // R5
  evict_oldest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fill && (&fValid)) |-> fAge[victimIdx] == OLDEST);

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> $stable(fValid) && $stable(mValid));
endmodule

// File: rtl/rfcCtrl.sv
module rfcCtrl import rfcPkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              filterHit,
  input  logic              mainHit,
  output rfcStrobe_t        strb,
  output logic              hitFilter,
  output logic              hitMain,
  output logic              missOut,
  output logic              promoteValid,
  output logic [ADDR_W-1:0] promoteAddr,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr
);
  always_comb begin
    hitFilter    = lookupValid && filterHit;
    hitMain      = lookupValid && !filterHit && mainHit;
    missOut      = lookupValid && !filterHit && !mainHit;
    strb.promote = hitFilter;
    strb.fill    = missOut;
    promoteValid = strb.promote;
    fillValid    = strb.fill;
    promoteAddr  = promoteValid ? lookupAddr : '0;
    fillAddr     = fillValid ? lookupAddr : '0;
  end
endmodule

// File: rtl/reuseFilterTop.sv
module reuseFilterTop import rfcPkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int FILT_N    = 8,
  parameter int MAIN_SETS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              hitFilter,
  output logic              hitMain,
  output logic              missOut,
  output logic              promoteValid,
  output logic [ADDR_W-1:0] promoteAddr,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr
);
  rfcStrobe_t strb;
  logic filterHit, mainHit;

  rfcData #(.ADDR_W(ADDR_W), .FILT_N(FILT_N), .MAIN_SETS(MAIN_SETS)) data_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .strb(strb), .filterHit(filterHit), .mainHit(mainHit));

  rfcCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .filterHit(filterHit), .mainHit(mainHit), .strb(strb),
    .hitFilter(hitFilter), .hitMain(hitMain), .missOut(missOut),
    .promoteValid(promoteValid), .promoteAddr(promoteAddr),
    .fillValid(fillValid), .fillAddr(fillAddr));

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> $onehot({hitFilter, hitMain, missOut}));

  // R8
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !(hitFilter || hitMain || missOut || promoteValid || fillValid));
endmodule

// File: tb/reuseFilterTop_tb.sv
module reuseFilterTop_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [15:0] lookupAddr = '0;
  logic hitFilter, hitMain, missOut, promoteValid, fillValid;
  logic [15:0] promoteAddr, fillAddr;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] addr;
    int          kind;   // 0 miss, 1 filter hit, 2 main hit
    string       req;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  reuseFilterTop dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .hitFilter(hitFilter), .hitMain(hitMain), .missOut(missOut),
    .promoteValid(promoteValid), .promoteAddr(promoteAddr),
    .fillValid(fillValid), .fillAddr(fillAddr));

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic doLookup(input logic [15:0] a, input int kind, input string req);
    expItem_t it;
    @(negedge clk);
    lookupValid = 1'b1;
    lookupAddr  = a;
    it.addr = a; it.kind = kind; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic idleCheck(input string req);
    @(negedge clk);
    lookupValid = 1'b0;
    lookupAddr  = 16'hFFFF;
    #(CLK_PERIOD/4);
    checks++;
    if ({hitFilter, hitMain, missOut, promoteValid, fillValid} != 5'b0) begin
      fails++;
      $display("FAIL %s idle outputs act=%b exp=00000", req,
               {hitFilter, hitMain, missOut, promoteValid, fillValid});
    end
  endtask

  // monitor: compares the result of each lookup against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (lookupValid && expQ.size() > 0) begin
        expItem_t it;
        logic [4:0] expFlags;
        logic [15:0] expProm, expFill;
        it = expQ.pop_front();
        case (it.kind)
          0: begin expFlags = 5'b00101; expProm = '0;      expFill = it.addr; end
          1: begin expFlags = 5'b10010; expProm = it.addr; expFill = '0;      end
          default: begin expFlags = 5'b01000; expProm = '0; expFill = '0; end
        endcase
        checks++;
        if ({hitFilter, hitMain, missOut, promoteValid, fillValid} != expFlags ||
            promoteAddr != expProm || fillAddr != expFill) begin
          fails++;
          $display("FAIL %s addr=%h act flags=%b prom=%h fill=%h exp flags=%b prom=%h fill=%h",
                   it.req, it.addr, {hitFilter, hitMain, missOut, promoteValid, fillValid},
                   promoteAddr, fillAddr, expFlags, expProm, expFill);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: quiet after reset, first touch misses
    idleCheck("R1");
    doLookup(16'h0105, 0, "R1 R2 first miss");
    doLookup(16'h0105, 1, "R3 second access promotes");
    doLookup(16'h0105, 2, "R4 main hit after promote");
    doLookup(16'h0105, 2, "R4 stays in main");
    // R7: same set, different tag
    doLookup(16'h0205, 0, "R7 conflicting line miss");
    doLookup(16'h0205, 1, "R7 conflicting promote");
    doLookup(16'h0105, 0, "R7 displaced line dropped");
    doLookup(16'h0205, 2, "R7 new owner hits main");
    // R9: idle gap keeps the filter entry
    idleCheck("R9");
    idleCheck("R9");
    idleCheck("R8");
    doLookup(16'h0105, 1, "R9 filter entry kept");
    // R5: nine single-use lines overflow the filter
    for (int i = 0; i < 9; i++) doLookup(16'h1000 + 16'(i), 0, "R5 single-use fill");
    doLookup(16'h1000, 0, "R5 oldest evicted");
    doLookup(16'h1002, 1, "R5 survivor still in filter");
    // R6: freed slot used first, then true oldest evicted
    doLookup(16'h2000, 0, "R6 fill into freed slot");
    doLookup(16'h2001, 0, "R6 fill evicts oldest");
    doLookup(16'h1004, 1, "R6 order kept");
    doLookup(16'h1003, 0, "R6 oldest was evicted");
    idleCheck("R8");
    wait (expQ.size() == 0);
    #(CLK_PERIOD);
    finishRun();
  end
endmodule